// File: doc/BRIEF.md
# Operand Bypass and Hazard Interlock Unit

This unit does the hazard control for a five-stage, in-order integer pipeline with the stages fetch, decode, execute, memory and writeback. Operands are read during decode, and the register file is written only in writeback. Each cycle the unit compares the two source register numbers of the instruction in decode against the destination of the instruction in execute and the destination of the instruction in memory. From that comparison it does one of two things. It can hold the fetch and decode latches and send a no-op into execute. Otherwise it registers, for each ALU operand, a select code that the operand multiplexer uses while the instruction executes.

Results travel through two holding latches on their way to the register file. The first holding latch takes the ALU output at the end of execute. The second holding latch receives that value one stage later, or receives load data at the end of the memory stage. A static mode input picks the policy. In interlock-only mode, every dependency on an unfinished result waits until the producer reaches writeback. In bypass mode, results are taken from the two holding latches, and only a load that is followed directly by its consumer costs a cycle. The register file writes in the first half of a cycle and is read in the second half, so a producer in writeback never needs help from this unit.

Top module: `fwd_ilock_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, both operand selects read 00 (register file). With no valid instruction in decode, the stall output stays low.
- R2: In bypass mode, a used source that matches the destination of a non-load instruction in execute causes no stall. On the next clock edge, that operand's select becomes 01 (first holding latch).
- R3: In bypass mode, a used source that matches only the destination of the instruction in memory causes no stall. On the next edge, the select becomes 10 (second holding latch). This holds whether that instruction is a load or an ALU operation.
- R4: When both execute and memory match the same source, the select is 01, because the younger result wins.
- R5: A source equal to register 0 never matches. An instruction whose write flag is low never matches. Neither case stalls nor forwards, in either mode.
- R6: In bypass mode, a load followed directly by an instruction that uses its destination inserts exactly one bubble. The consumer then executes with select 10.
- R7: In interlock-only mode, a dependency on the instruction in execute or in memory stalls until the producer reaches writeback. A directly following consumer therefore waits two bubbles, and a consumer one slot later waits one bubble. All selects stay 00.
- R8: The stall and bubble outputs rise and fall together. A bubble that enters execute carries select 00 on both operands.
- R9: A source whose use flag is low, or an instruction in decode whose valid flag is low, causes neither a stall nor forwarding, even when the register numbers match a load.
- R10: The two operands are resolved independently. One instruction may take 01 on one operand and 00 or 10 on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_en | input | 1 | Static mode: 1 = bypass, 0 = interlock only |
| id_valid | input | 1 | Decode holds a real instruction |
| id_src_a | input | REG_W | First source register number in decode |
| id_use_a | input | 1 | First source is read |
| id_src_b | input | REG_W | Second source register number in decode |
| id_use_b | input | 1 | Second source is read |
| ex_dest | input | REG_W | Destination of the instruction in execute |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| ma_dest | input | REG_W | Destination of the instruction in memory |
| ma_wr | input | 1 | Instruction in memory writes a register |
| sel_a | output | 2 | First operand mux select for the instruction in execute (00 register file, 01 first holding latch, 10 second holding latch) |
| sel_b | output | 2 | Second operand mux select, same encoding |
| stall_if_id | output | 1 | Hold the fetch and decode latches this cycle |
| bubble_ex | output | 1 | Send a no-op into execute at the next edge |

## Verification
The stall and bubble outputs are combinational from the latch contents, so they are due in the same cycle as the decode state that causes them. The bench samples them at the falling edge, before the model pipeline advances. Operand selects are registered on the edge that moves an instruction from decode into execute, so they are due one cycle after that instruction was in decode. The bench records them at the next falling edge, tagged with the instruction the model holds in execute. Bubble counts come from the stall samples taken across a whole sequence.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    typedef enum logic [1:0] {
        SRC_RF   = 2'b00,
        SRC_OUT0 = 2'b01,
        SRC_OUT1 = 2'b10
    } opsrc_e;

    localparam int NUM_OPS = 2;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             use_i,
    input  logic [REG_W-1:0] ex_dest,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] ma_dest,
    input  logic             ma_wr,
    output logic             hit_ex,
    output logic             hit_ma,
    output logic             load_near
);
    logic live;

    // register 0 is hard-wired, so a read of it depends on nobody
    assign live      = use_i && (src != '0);
    assign hit_ex    = live && ex_wr && (ex_dest == src);
    assign hit_ma    = live && ma_wr && (ma_dest == src);
    assign load_near = hit_ex && ex_load;

endmodule

// File: rtl/hz_pick.sv
module hz_pick
    import hazard_pkg::*;
(
    input  logic   fwd_en,
    input  logic   hit_ex,
    input  logic   hit_ma,
    input  logic   load_near,
    output opsrc_e sel_nx,
    output logic   hold
);
    always_comb begin
        sel_nx = SRC_RF;
        hold   = 1'b0;
        unique case (fwd_en)
            1'b1: begin
                // load data exists only after memory stage: wait one slot
                hold = load_near;
                if (hit_ex)      sel_nx = SRC_OUT0;
                else if (hit_ma) sel_nx = SRC_OUT1;
            end
            default: begin
                hold = hit_ex || hit_ma;
            end
        endcase
    end

endmodule

// File: rtl/fwd_ilock_unit.sv
module fwd_ilock_unit
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_src_a,
    input  logic             id_use_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_use_b,
    input  logic [REG_W-1:0] ex_dest,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] ma_dest,
    input  logic             ma_wr,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic             stall_if_id,
    output logic             bubble_ex
);
    logic [REG_W-1:0] op_src [NUM_OPS];
    logic             op_use [NUM_OPS];
    logic [NUM_OPS-1:0] hit_ex, hit_ma, load_near, hold;
    opsrc_e           sel_nx [NUM_OPS];
    opsrc_e           sel_q  [NUM_OPS];
    logic             hold_any;

    assign op_src[0] = id_src_a;
    assign op_src[1] = id_src_b;
    assign op_use[0] = id_valid && id_use_a;
    assign op_use[1] = id_valid && id_use_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_match #(.REG_W(REG_W)) u_match (
            .src       (op_src[g]),
            .use_i     (op_use[g]),
            .ex_dest   (ex_dest),
            .ex_wr     (ex_wr),
            .ex_load   (ex_load),
            .ma_dest   (ma_dest),
            .ma_wr     (ma_wr),
            .hit_ex    (hit_ex[g]),
            .hit_ma    (hit_ma[g]),
            .load_near (load_near[g])
        );

        hz_pick u_pick (
            .fwd_en    (fwd_en),
            .hit_ex    (hit_ex[g]),
            .hit_ma    (hit_ma[g]),
            .load_near (load_near[g]),
            .sel_nx    (sel_nx[g]),
            .hold      (hold[g])
        );

        // select travels with the instruction into execute; a bubble reads the file
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sel_q[g] <= SRC_RF;
            else if (hold_any) sel_q[g] <= SRC_RF;
            else               sel_q[g] <= sel_nx[g];
        end
    end

    assign hold_any    = |hold;
    assign stall_if_id = hold_any;
    assign bubble_ex   = hold_any;
    assign sel_a       = sel_q[0];
    assign sel_b       = sel_q[1];

    // R8: a bubble entering execute reads the register file
    p_bubble_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ex |=> (sel_a == 2'b00 && sel_b == 2'b00));

    // R7: interlock-only mode never forwards
    p_off_no_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |=> (sel_a == 2'b00 && sel_b == 2'b00));

    // R5: register 0 never forwards
    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_src_a == '0) |=> (sel_a == 2'b00));

    // R2: execute-stage ALU producer forwards from first latch without stall
    p_ex_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && id_valid && id_use_a && ex_wr && !ex_load &&
         ex_dest == id_src_a && ex_dest != '0 && !(id_valid && id_use_b &&
         ex_wr && ex_load && ex_dest == id_src_b))
        |-> (!stall_if_id ##1 sel_a == 2'b01));

    // R6: a load in execute feeding decode always holds decode
    p_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_use_b && ex_wr && ex_load && ex_dest == id_src_b &&
         ex_dest != '0) |-> stall_if_id);

endmodule

// File: tb/sim_fwd_ilock_unit.sv
module sim_fwd_ilock_unit;

    typedef struct packed {
        logic [4:0] d;
        logic [4:0] a;
        logic [4:0] b;
        logic       ua;
        logic       ub;
        logic       wr;
        logic       ld;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_en = 1'b1;
    logic [1:0] sel_a, sel_b;
    logic stall_if_id, bubble_ex;

    ins_t prog [8];
    ins_t id_i, ex_i, ma_i;
    int   id_tag, ex_tag, pc;
    int   sa [8];
    int   sb [8];
    int   total = 0;
    int   bad = 0;
    int   r8bad = 0;

    always #4 clk = ~clk;

    fwd_ilock_unit u0 (
        .clk (clk), .rst_n (rst_n), .fwd_en (fwd_en),
        .id_valid (id_tag >= 0),
        .id_src_a (id_i.a), .id_use_a (id_i.ua),
        .id_src_b (id_i.b), .id_use_b (id_i.ub),
        .ex_dest (ex_i.d), .ex_wr (ex_i.wr), .ex_load (ex_i.ld),
        .ma_dest (ma_i.d), .ma_wr (ma_i.wr),
        .sel_a (sel_a), .sel_b (sel_b),
        .stall_if_id (stall_if_id), .bubble_ex (bubble_ex)
    );

    function automatic ins_t mk(input int d, a, b, ua, ub, wr, ld);
        ins_t t;
        t.d = 5'(d); t.a = 5'(a); t.b = 5'(b);
        t.ua = ua[0]; t.ub = ub[0]; t.wr = wr[0]; t.ld = ld[0];
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input bit fwd, input int n, output int bub);
        bit st, done;
        fwd_en = fwd;
        id_i = '0; ex_i = '0; ma_i = '0;
        id_tag = -1; ex_tag = -1;
        for (int k = 0; k < 8; k++) begin sa[k] = -1; sb[k] = -1; end
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        id_i = prog[0]; id_tag = 0; pc = 1; bub = 0; done = 1'b0;
        for (int c = 0; c < 30 && !done; c++) begin
            @(negedge clk);
            if (ex_tag >= 0) begin
                sa[ex_tag] = int'(sel_a); sb[ex_tag] = int'(sel_b);
                if (ex_tag == n - 1) done = 1'b1;
            end else if (sel_a != 2'b00 || sel_b != 2'b00) r8bad++;
            if (stall_if_id !== bubble_ex) r8bad++;
            st = stall_if_id;
            if (st) bub++;
            @(posedge clk); #1;
            ma_i = ex_i;
            if (st) begin
                ex_i = '0; ex_tag = -1;
            end else begin
                ex_i = id_i; ex_tag = id_tag;
                if (pc < n) begin id_i = prog[pc]; id_tag = pc; end
                else begin id_i = '0; id_tag = -1; end
                pc++;
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; id_i = '0; ex_i = '0; ma_i = '0; id_tag = -1; ex_tag = -1;
        @(negedge clk);
        chk(sel_a == 2'b00 && sel_b == 2'b00, "R1", int'({sel_a, sel_b}), 0);
        chk(stall_if_id == 1'b0, "R1", int'(stall_if_id), 0);
    endtask

    task automatic t_alu_chain;
        int bub;
        prog[0] = mk(1, 2, 3, 1, 1, 1, 0);
        prog[1] = mk(4, 1, 5, 1, 1, 1, 0);
        prog[2] = mk(6, 7, 1, 1, 1, 1, 0);
        run_seq(1'b1, 3, bub);
        chk(bub == 0, "R2", bub, 0);
        chk(sa[1] == 1, "R2", sa[1], 1);
        chk(sb[1] == 0, "R10", sb[1], 0);
        chk(sb[2] == 2, "R3", sb[2], 2);
        chk(sa[2] == 0, "R10", sa[2], 0);
    endtask

    task automatic t_priority;
        int bub;
        prog[0] = mk(1, 2, 3, 1, 1, 1, 0);
        prog[1] = mk(1, 4, 5, 1, 1, 1, 0);
        prog[2] = mk(2, 1, 1, 1, 1, 1, 0);
        run_seq(1'b1, 3, bub);
        chk(sa[2] == 1 && sb[2] == 1, "R4", sa[2] * 4 + sb[2], 5);
    endtask

    task automatic t_zero_nowrite(input bit fwd);
        int bub;
        prog[0] = mk(0, 2, 3, 1, 1, 1, 1);
        prog[1] = mk(5, 0, 0, 1, 1, 1, 0);
        prog[2] = mk(3, 1, 2, 1, 1, 0, 0);
        prog[3] = mk(6, 3, 3, 1, 1, 1, 0);
        run_seq(fwd, 4, bub);
        chk(bub == 0, "R5", bub, 0);
        chk(sa[1] == 0 && sb[1] == 0, "R5", sa[1] * 4 + sb[1], 0);
        chk(sa[3] == 0 && sb[3] == 0, "R5", sa[3] * 4 + sb[3], 0);
    endtask

    task automatic t_load_use_on;
        int bub;
        prog[0] = mk(1, 2, 0, 1, 0, 1, 1);
        prog[1] = mk(3, 1, 2, 1, 1, 1, 0);
        run_seq(1'b1, 2, bub);
        chk(bub == 1, "R6", bub, 1);
        chk(sa[1] == 2, "R6", sa[1], 2);
        prog[0] = mk(1, 2, 0, 1, 0, 1, 1);
        prog[1] = mk(7, 8, 9, 1, 1, 1, 0);
        prog[2] = mk(3, 4, 1, 1, 1, 1, 0);
        run_seq(1'b1, 3, bub);
        chk(bub == 0, "R3", bub, 0);
        chk(sb[2] == 2, "R3", sb[2], 2);
    endtask

    task automatic t_interlock_only;
        int bub;
        prog[0] = mk(1, 2, 0, 1, 0, 1, 1);
        prog[1] = mk(3, 1, 2, 1, 1, 1, 0);
        run_seq(1'b0, 2, bub);
        chk(bub == 2, "R7", bub, 2);
        chk(sa[1] == 0, "R7", sa[1], 0);
        prog[0] = mk(1, 2, 3, 1, 1, 1, 0);
        prog[1] = mk(4, 1, 5, 1, 1, 1, 0);
        run_seq(1'b0, 2, bub);
        chk(bub == 2, "R7", bub, 2);
        prog[0] = mk(1, 2, 3, 1, 1, 1, 0);
        prog[1] = mk(9, 8, 8, 1, 1, 1, 0);
        prog[2] = mk(4, 5, 1, 1, 1, 1, 0);
        run_seq(1'b0, 3, bub);
        chk(bub == 1, "R7", bub, 1);
        chk(sb[2] == 0, "R7", sb[2], 0);
    endtask

    task automatic t_unused;
        int bub;
        prog[0] = mk(1, 2, 0, 1, 0, 1, 1);
        prog[1] = mk(3, 1, 1, 0, 0, 1, 0);
        run_seq(1'b0, 2, bub);
        chk(bub == 0, "R9", bub, 0);
        run_seq(1'b1, 2, bub);
        chk(bub == 0, "R9", bub, 0);
        chk(sa[1] == 0 && sb[1] == 0, "R9", sa[1] * 4 + sb[1], 0);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_alu_chain();
        t_priority();
        t_zero_nowrite(1'b1);
        t_zero_nowrite(1'b0);
        t_load_use_on();
        t_interlock_only();
        t_unused();
        chk(r8bad == 0, "R8", r8bad, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule